// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a filter inner loop. Each clock cycle it multiplies two signed Q1.23 operands into a full-precision product and then does one of four things with the accumulator: it keeps the value, loads the product, adds the product or subtracts it. The product is renormalised to Q1.47 by dropping its redundant sign bit. It is then sign-extended into an accumulator that has eight bits of headroom above the product, so long runs of taps can grow past the one-unit range without wrapping.

A separate store path reads the accumulator continuously. It reduces the accumulator to a 24-bit Q1.23 word using one of three rounding modes, which the caller picks on each read. If the rounded value does not fit in the data word, the output clamps to the nearest end of the range and an overflow flag is raised. The usual sequence is one load, then a series of add or subtract steps, then a read of the rounded word.

Top module: `mac_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the accumulator to zero. The rounded word then reads 0 with the overflow flag low.
- R2: The product is 2·a·b, treated as a Q1.47 value and sign-extended to 56 bits. Op code 01 replaces the accumulator with this product at the next rising edge.
- R3: When both operands are -1.0 (0x800000), the product is replaced by the largest positive Q1.47 value, 2^47-1.
- R4: Op code 10 adds the product to the accumulator. The accumulator is 56 bits wide, so sums up to about ±2^55 are held exactly.
- R5: Op code 11 subtracts the product from the accumulator.
- R6: Op code 00 leaves the accumulator unchanged, whatever the operand values are.
- R7: One operation completes every cycle. The accumulator output shows the effect of an operation right after the rising edge at which it was presented.
- R8: Rounding code 00 (and the spare code 11) truncates: the rounded value is floor(acc / 2^24).
- R9: Rounding code 01 rounds to nearest with ties upward: floor((acc + 2^23) / 2^24).
- R10: Rounding code 10 is convergent. It behaves like R9, except that when the dropped 24 bits are exactly 0x800000 the kept value is made even: floor(acc / 2^24) plus its own LSB.
- R11: If the rounded value is above 2^23-1 or below -2^23, the word becomes 0x7FFFFF or 0x800000 respectively and the overflow flag is 1. Otherwise the word is the rounded value and the flag is 0.
- R12: The store path is combinational from the accumulator. A change of rounding code changes the word with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | 00 hold, 01 load product, 10 add product, 11 subtract product |
| rnd_i | input | 2 | 00 truncate, 01 nearest, 10 convergent, 11 truncate |
| a_i | input | 24 | Operand A, signed Q1.23 |
| b_i | input | 24 | Operand B, signed Q1.23 |
| acc_o | output | 56 | Accumulator, signed Q9.47 |
| word_o | output | 24 | Rounded, saturated Q1.23 word |
| ovf_o | output | 1 | High when word_o was clamped |

## Verification
Accumulator results are due one rising edge after the operation is presented. The bench drives each operation at a falling edge and returns the op code to hold at the next falling edge. It reads acc_o at that same falling edge, after exactly one register stage. The rounded word depends on no register beyond the accumulator. For every accumulator value, the bench therefore walks all four rounding codes within the same low clock phase and samples one time unit after each change. Expected values come from integer arithmetic on 64-bit models of the product, the sum and the three rounding rules.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_LOAD = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC = 2'b00,
        RND_NEAR  = 2'b01,
        RND_CONV  = 2'b10,
        RND_SPARE = 2'b11
    } mac_rnd_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 24,
    parameter int AW = 56
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [AW-1:0] prod_o
);
    localparam int PW = 2 * DW;
    localparam int GW = AW - PW;

    logic signed [DW-1:0] a_s;
    logic signed [DW-1:0] b_s;
    logic signed [PW-1:0] raw;
    logic        [PW-1:0] norm;
    logic                 flip;

    always_comb begin
        a_s  = $signed(a_i);
        b_s  = $signed(b_i);
        raw  = a_s * b_s;
        // Only (-1)*(-1) makes the two top bits differ.
        flip = raw[PW-1] ^ raw[PW-2];
        if (flip) begin
            norm = {1'b0, {(PW-1){1'b1}}};
        end else begin
            norm = {raw[PW-2:0], 1'b0};
        end
        prod_o = {{GW{norm[PW-1]}}, norm};
    end

    always_comb begin
        if (a_i == {1'b1, {(DW-1){1'b0}}} && b_i == {1'b1, {(DW-1){1'b0}}}) begin
            AST_MIN_SQUARE_CLAMPS: assert (prod_o == {{(GW+1){1'b0}}, {(PW-1){1'b1}}}); // R3
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int AW = 56
) (
    input  logic                clk,
    input  logic                rst,
    input  mac_pkg::mac_op_e    op_i,
    input  logic [AW-1:0]       prod_i,
    output logic [AW-1:0]       acc_o
);
    import mac_pkg::*;

    typedef struct packed {
        logic [AW-1:0] acc;
    } acc_state_t;

    acc_state_t state_d;
    acc_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.acc = '0;
        end else begin
            case (op_i)
                OP_LOAD: state_d.acc = prod_i;
                OP_ADD:  state_d.acc = state_q.acc + prod_i;
                OP_SUB:  state_d.acc = state_q.acc - prod_i;
                default: state_d.acc = state_q.acc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign acc_o = state_q.acc;

    AST_RESET_ZEROES: assert property (@(posedge clk) rst |=> (acc_o == '0)); // R1
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_HOLD) |=> $stable(acc_o)); // R6
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> (acc_o == $past(prod_i))); // R2
    AST_ADD_STEPS: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADD) |=> (acc_o == $past(acc_o) + $past(prod_i))); // R4
    AST_SUB_STEPS: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUB) |=> (acc_o == $past(acc_o) - $past(prod_i))); // R5

endmodule

// File: rtl/mac_store.sv
module mac_store #(
    parameter int DW = 24,
    parameter int AW = 56
) (
    input  logic [AW-1:0]       acc_i,
    input  mac_pkg::mac_rnd_e   rnd_i,
    output logic [DW-1:0]       word_o,
    output logic                ovf_o
);
    import mac_pkg::*;

    localparam int KW = AW + 1 - DW;
    localparam logic [AW:0] HALF = {{(AW+1-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};

    logic [AW:0]   acc_x;
    logic [AW:0]   biased;
    logic [KW-1:0] flr;
    logic [KW-1:0] near;
    logic [KW-1:0] conv;
    logic [KW-1:0] kept;
    logic          tie;
    logic          fits;

    always_comb begin
        acc_x  = {acc_i[AW-1], acc_i};
        biased = acc_x + HALF;
        flr    = acc_x[AW:DW];
        near   = biased[AW:DW];
        tie    = (acc_i[DW-1:0] == HALF[DW-1:0]);
        conv   = tie ? (flr + {{(KW-1){1'b0}}, flr[0]}) : near;
        case (rnd_i)
            RND_NEAR: kept = near;
            RND_CONV: kept = conv;
            default:  kept = flr;
        endcase
        fits = (&kept[KW-1:DW-1]) | ~(|kept[KW-1:DW-1]);
        if (fits) begin
            word_o = kept[DW-1:0];
            ovf_o  = 1'b0;
        end else begin
            word_o = kept[KW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
            ovf_o  = 1'b1;
        end
    end

    always_comb begin
        if (ovf_o) begin
            AST_CLAMP_AT_LIMIT: assert (word_o == {1'b1, {(DW-1){1'b0}}} ||
                                        word_o == {1'b0, {(DW-1){1'b1}}}); // R11
            AST_CLAMP_SIGN: assert (word_o[DW-1] == acc_i[AW-1]); // R11
        end
        if (rnd_i == RND_CONV && tie && !ovf_o) begin
            AST_TIE_GOES_EVEN: assert (word_o[0] == 1'b0); // R10
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int DW = 24,
    parameter int GW = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             op_i,
    input  logic [1:0]             rnd_i,
    input  logic [DW-1:0]          a_i,
    input  logic [DW-1:0]          b_i,
    output logic [2*DW+GW-1:0]     acc_o,
    output logic [DW-1:0]          word_o,
    output logic                   ovf_o
);
    import mac_pkg::*;

    localparam int PW = 2 * DW;
    localparam int AW = PW + GW;

    logic [AW-1:0] prod;
    logic [AW-1:0] acc_q;
    mac_op_e       op_e;
    mac_rnd_e      rnd_e;

    assign op_e  = mac_op_e'(op_i);
    assign rnd_e = mac_rnd_e'(rnd_i);

    mac_mult #(.DW(DW), .AW(AW)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    mac_accum #(.AW(AW)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op_e),
        .prod_i (prod),
        .acc_o  (acc_q)
    );

    mac_store #(.DW(DW), .AW(AW)) u_store (
        .acc_i  (acc_q),
        .rnd_i  (rnd_e),
        .word_o (word_o),
        .ovf_o  (ovf_o)
    );

    assign acc_o = acc_q;

    AST_RESET_WORD_ZERO: assert property (@(posedge clk) rst |=> (word_o == '0 && !ovf_o)); // R1

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_i = 2'b00;
    logic [1:0]  rnd_i = 2'b00;
    logic [23:0] a_i = '0;
    logic [23:0] b_i = '0;
    logic [55:0] acc_o;
    logic [23:0] word_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;
    longint model = 0;

    mac_unit dut (
        .clk(clk), .rst(rst), .op_i(op_i), .rnd_i(rnd_i),
        .a_i(a_i), .b_i(b_i), .acc_o(acc_o), .word_o(word_o), .ovf_o(ovf_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int val(input int k);
        case (k)
            0: return -8388608;
            1: return 8388607;
            2: return 0;
            3: return 1;
            4: return -1;
            5: return 2048;
            6: return -2048;
            7: return 6144;
            8: return 1234567;
            9: return -7654321;
            10: return 3000001;
            default: return -4194304;
        endcase
    endfunction

    function automatic longint prod_of(input int a, input int b);
        longint p;
        p = longint'(a) * longint'(b) * 2;
        if (p == (longint'(1) <<< 47)) p = (longint'(1) <<< 47) - 1;
        return p;
    endfunction

    function automatic longint rounded(input longint acc, input int mode);
        longint fl;
        longint lo;
        fl = acc >>> 24;
        lo = acc & 64'hFFFFFF;
        case (mode)
            1: return (acc + 64'sd8388608) >>> 24;
            2: return (lo == 64'sd8388608) ? fl + (fl & 1) : ((acc + 64'sd8388608) >>> 24);
            default: return fl;
        endcase
    endfunction

    task automatic check_acc(input string req);
        longint got;
        got = longint'($signed(acc_o));
        checks++;
        if (got !== model) begin
            errors++;
            $display("FAIL %s acc actual %0d expected %0d", req, got, model);
        end
    endtask

    task automatic check_word(input string req, input int mode);
        longint r;
        int     exp_w;
        logic   exp_o;
        int     got;
        r = rounded(model, mode);
        if (r > 8388607) begin exp_w = 8388607; exp_o = 1'b1; end
        else if (r < -8388608) begin exp_w = -8388608; exp_o = 1'b1; end
        else begin exp_w = int'(r); exp_o = 1'b0; end
        got = int'($signed(word_o));
        checks++;
        if (got != exp_w || ovf_o !== exp_o) begin
            errors++;
            $display("FAIL %s mode %0d word/ovf actual %0d/%0b expected %0d/%0b",
                     req, mode, got, ovf_o, exp_w, exp_o);
        end
    endtask

    task automatic all_modes(input string req);
        for (int m = 0; m < 4; m++) begin
            rnd_i = m[1:0];
            #1;
            check_word(req, m);
        end
    endtask

    task automatic step(input logic [1:0] op, input int a, input int b);
        op_i = op;
        a_i = a[23:0];
        b_i = b[23:0];
        case (op)
            2'b01: model = prod_of(a, b);
            2'b10: model = model + prod_of(a, b);
            2'b11: model = model - prod_of(a, b);
            default: model = model;
        endcase
        @(negedge clk);
        op_i = 2'b00;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = 0;
        check_acc("R1");
        all_modes("R1");

        // R2 R3 R7 R8 R9 R10 R11 R12: load sweep over every operand pair, all rounding codes
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                step(2'b01, val(i), val(j));
                check_acc((i == 0 && j == 0) ? "R3" : "R2");
                all_modes("R12");
            end
        end

        // R10 tie cases: 2^23 (even kept 0), 3*2^23 (odd kept 1), -2^23 (odd kept -1)
        step(2'b01, 2048, 2048);
        check_acc("R10");
        all_modes("R10");
        step(2'b01, 6144, 2048);
        check_acc("R10");
        all_modes("R10");
        step(2'b01, -2048, 2048);
        check_acc("R10");
        all_modes("R10");

        // R4 / R5 accumulate and subtract chains
        step(2'b01, 0, 0);
        for (int i = 0; i < 12; i++) begin
            step(2'b10, val(i), val((i * 5 + 1) % 12));
            check_acc("R4");
            all_modes("R4");
        end
        for (int i = 0; i < 12; i++) begin
            step(2'b11, val((i * 7 + 3) % 12), val(i));
            check_acc("R5");
            all_modes("R5");
        end

        // R6: hold ignores operands
        for (int i = 0; i < 6; i++) begin
            step(2'b00, val(i), val(11 - i));
            check_acc("R6");
        end

        // R4 / R11: guard bits absorb 200 max*max terms, word saturates high
        step(2'b01, 8388607, 8388607);
        for (int i = 0; i < 199; i++) step(2'b10, 8388607, 8388607);
        check_acc("R4");
        all_modes("R11");
        // R5 / R11: drive well negative, word saturates low
        for (int i = 0; i < 400; i++) step(2'b11, 8388607, 8388607);
        check_acc("R5");
        all_modes("R11");

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = 0;
        check_acc("R1");
        all_modes("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule